// File: doc/BRIEF.md
# Dependency-Triggered Register Pre-fetch Unit

This block sits inside the bus wrapper of a core and keeps a local copy (a shadow) of every core register, so that a system-bus read is answered in the same cycle without waiting for the core. Shadows are kept fresh in two ways. Each register has an age counter; when the counter runs out, the register is re-read from the core. A small table of update arcs also lists which bus events change which core registers. When such an event occurs, the affected register is marked urgent and re-read ahead of the age-driven refreshes.

Each arc names a source register, whether a bus read or a bus write of that source fires it, and a target register. A bus write goes to the core through the same internal port, ahead of any pre-fetch. After the write, both the written register and the targets of its write arcs are re-read. A bus read of a source places its read arcs in a pending list. One cycle later they fire and mark their targets urgent. A software-visible table port loads the arcs.

Top module: `dep_prefetch_unit`

## Requirements
- R1: `bus_rdata` shows the shadow of `bus_addr` combinationally in the same cycle. Shadows reset to zero and change only when an internal read transfer completes.
- R2: Reset sets every age counter to zero, so all registers are fetched right after reset. After a register is fetched, its counter restarts at AGE_LIMIT, and the register is fetched again once the counter reaches zero.
- R3: A core register that changes with no arc event stays stale in its shadow until its age counter expires.
- R4: A transfer on the internal port takes two cycles. `int_req` is high in the first cycle only. `int_addr` and `int_we` stay stable in both cycles. Read data is captured at the end of the second cycle. A new transfer may start in the cycle right after the second cycle.
- R5: A bus write is accepted only when `bus_ready` is 1. After acceptance, `bus_ready` is 0 until the write is issued. A `bus_wr` pulse seen while `bus_ready` is 0 is ignored and never reaches the core.
- R6: When a transfer may start, a pending bus write is issued before any pre-fetch.
- R7: An accepted bus write to register X marks X urgent. It also marks urgent the target of every valid arc whose source is X and whose trigger is write.
- R8: A bus read of X arms every valid arc whose source is X and whose trigger is read. An armed arc fires one cycle later, marks its target urgent and is disarmed. On an idle unit, the target's `int_req` comes three cycles after the cycle of the bus read.
- R9: Urgent registers are fetched before registers whose age counter is zero. Within each class, the lowest index goes first.
- R10: A register already marked urgent is not queued twice. Several arcs that fire for the same target produce a single fetch.
- R11: When `cfg_we` is high, arc `cfg_idx` is loaded from `cfg_valid`, `cfg_on_read` (1 = read trigger, 0 = write trigger), `cfg_src` and `cfg_tgt`. Reset clears all valid bits. Arcs that are invalid, or whose trigger type does not match the event, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW | Register index for a bus read or write |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Shadow value of `bus_addr` |
| bus_ready | output | 1 | A bus write can be accepted |
| int_req | output | 1 | First cycle of an internal transfer |
| int_we | output | 1 | Current internal transfer is a write |
| int_addr | output | AW | Internal register index |
| int_wdata | output | DW | Internal write data |
| int_rdata | input | DW | Core register value for `int_addr` |
| cfg_we | input | 1 | Load one arc entry |
| cfg_idx | input | IW | Arc entry index |
| cfg_valid | input | 1 | Entry is active |
| cfg_on_read | input | 1 | Trigger type: 1 read, 0 write |
| cfg_src | input | AW | Source register of the arc |
| cfg_tgt | input | AW | Target register of the arc |

## Verification
The bench builds the unit with NREG=8, DW=16, NARC=8 and AGE_LIMIT=400. With an age period that long, every fetch caused by an arc happens well apart from the age-driven bursts, so the bench can count it at the internal port and time it to the exact cycle. The same period is still short enough that one full age expiry fits in the run, which makes both stale-until-expiry and refresh-on-expiry observable. The bench ties two write arcs to the same target so that the merging of duplicate requests shows up as a single fetch.

// File: rtl/dep_prefetch_unit.sv
module dep_prefetch_unit #(
  parameter int NREG      = 8,
  parameter int DW        = 16,
  parameter int NARC      = 8,
  parameter int AGE_LIMIT = 400
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(NREG)-1:0]   bus_addr,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [DW-1:0]             bus_wdata,
  output logic [DW-1:0]             bus_rdata,
  output logic                      bus_ready,
  output logic                      int_req,
  output logic                      int_we,
  output logic [$clog2(NREG)-1:0]   int_addr,
  output logic [DW-1:0]             int_wdata,
  input  logic [DW-1:0]             int_rdata,
  input  logic                      cfg_we,
  input  logic [$clog2(NARC)-1:0]   cfg_idx,
  input  logic                      cfg_valid,
  input  logic                      cfg_on_read,
  input  logic [$clog2(NREG)-1:0]   cfg_src,
  input  logic [$clog2(NREG)-1:0]   cfg_tgt
);
  localparam int AW = $clog2(NREG);
  localparam int GW = $clog2(AGE_LIMIT + 1);

  typedef enum logic [1:0] {P_IDLE, P_A, P_B} phase_t;

  logic [DW-1:0]   shadow  [NREG];
  logic [GW-1:0]   age     [NREG];
  logic [AW-1:0]   arc_src [NARC];
  logic [AW-1:0]   arc_tgt [NARC];
  logic [NARC-1:0] arc_v, arc_rd, arc_pend;

  logic [NREG-1:0] urgent, due, urg_set, busy_mask;
  phase_t          phase;
  logic [AW-1:0]   cur_addr, wr_addr, pick_urg, pick_due;
  logic            cur_we, wr_pend, have_urg, have_due;
  logic [DW-1:0]   cur_wdata, wr_data;
  logic            wr_acc, can_issue, issue_wr, issue_urg, issue_due, go, done_rd;

  assign bus_rdata = shadow[bus_addr];
  assign bus_ready = !wr_pend;
  assign wr_acc    = bus_wr && !wr_pend;

  assign int_req   = (phase == P_A);
  assign int_we    = (phase != P_IDLE) && cur_we;
  assign int_addr  = cur_addr;
  assign int_wdata = cur_wdata;

  assign can_issue = (phase == P_IDLE) || (phase == P_B);
  assign done_rd   = (phase == P_B) && !cur_we;
  assign busy_mask = (phase != P_IDLE && !cur_we) ? (NREG'(1) << cur_addr) : '0;

  always_comb begin
    for (int i = 0; i < NREG; i++) due[i] = (age[i] == '0);
    due = due & ~busy_mask;
  end

  always_comb begin
    urg_set = '0;
    if (wr_acc) begin
      urg_set[bus_addr] = 1'b1;
      for (int k = 0; k < NARC; k++)
        if (arc_v[k] && !arc_rd[k] && arc_src[k] == bus_addr) urg_set[arc_tgt[k]] = 1'b1;
    end
    for (int k = 0; k < NARC; k++)
      if (arc_pend[k]) urg_set[arc_tgt[k]] = 1'b1;
  end

  always_comb begin
    have_urg = 1'b0;
    have_due = 1'b0;
    pick_urg = '0;
    pick_due = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (urgent[i]) begin have_urg = 1'b1; pick_urg = AW'(i); end
      if (due[i])    begin have_due = 1'b1; pick_due = AW'(i); end
    end
  end

  assign issue_wr  = can_issue && wr_pend;
  assign issue_urg = can_issue && !wr_pend && have_urg;
  assign issue_due = can_issue && !wr_pend && !have_urg && have_due;
  assign go        = issue_wr || issue_urg || issue_due;

  always_ff @(posedge clk) begin
    if (rst) begin
      arc_v <= '0;
      arc_rd <= '0;
      for (int k = 0; k < NARC; k++) begin
        arc_src[k] <= '0;
        arc_tgt[k] <= '0;
      end
    end else if (cfg_we) begin
      arc_v[cfg_idx]   <= cfg_valid;
      arc_rd[cfg_idx]  <= cfg_on_read;
      arc_src[cfg_idx] <= cfg_src;
      arc_tgt[cfg_idx] <= cfg_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) arc_pend <= '0;
    else
      for (int k = 0; k < NARC; k++)
        arc_pend[k] <= bus_rd && arc_v[k] && arc_rd[k] && (arc_src[k] == bus_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (wr_acc) begin
      wr_pend <= 1'b1;
      wr_addr <= bus_addr;
      wr_data <= bus_wdata;
    end else if (issue_wr) begin
      wr_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) urgent <= '0;
    else urgent <= (urgent & ~(issue_urg ? (NREG'(1) << pick_urg) : '0)) | urg_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= P_IDLE;
      cur_addr  <= '0;
      cur_we    <= 1'b0;
      cur_wdata <= '0;
    end else if (go) begin
      phase     <= P_A;
      cur_we    <= issue_wr;
      cur_wdata <= wr_data;
      cur_addr  <= issue_wr ? wr_addr : (issue_urg ? pick_urg : pick_due);
    end else if (phase == P_A) begin
      phase <= P_B;
    end else begin
      phase <= P_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        shadow[i] <= '0;
        age[i]    <= '0;
      end
    end else begin
      if (done_rd) shadow[cur_addr] <= int_rdata;
      for (int i = 0; i < NREG; i++) begin
        if (done_rd && cur_addr == AW'(i)) age[i] <= GW'(AGE_LIMIT);
        else if (age[i] != '0)             age[i] <= age[i] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dep_prefetch_unit_chk.sv
module dep_prefetch_unit_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          bus_ready,
  input logic          int_req,
  input logic          int_we,
  input logic [AW-1:0] int_addr
);
  assert_req_single_R4: assert property (@(posedge clk) disable iff (rst)
    int_req |=> !int_req);

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (rst)
    int_req |=> ($stable(int_addr) && $stable(int_we)));

  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ready) |-> $past(bus_wr));

  assert_write_first_R6: assert property (@(posedge clk) disable iff (rst)
    (int_req && !int_we) |-> $past(bus_ready));
endmodule

bind dep_prefetch_unit dep_prefetch_unit_chk #(.AW($clog2(NREG))) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_ready(bus_ready),
  .int_req(int_req), .int_we(int_we), .int_addr(int_addr)
);

// File: tb/dep_prefetch_unit_test.sv
`timescale 1ns/1ps
module dep_prefetch_unit_test;
  localparam int NREG = 8, DW = 16, NARC = 8, AGE_LIMIT = 400;
  localparam int AW = $clog2(NREG), IW = $clog2(NARC);

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0, int_addr, cfg_src = '0, cfg_tgt = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, bus_ready, int_req, int_we;
  logic [DW-1:0] bus_wdata = '0, bus_rdata, int_wdata, int_rdata;
  logic cfg_we = 1'b0, cfg_valid = 1'b0, cfg_on_read = 1'b0;
  logic [IW-1:0] cfg_idx = '0;

  logic [DW-1:0] core [NREG];
  int checks = 0, fails = 0, cyc = 0, rd_cyc = 0;
  int rd_cnt [NREG], wr_cnt [NREG], last_rd [NREG], last_wr [NREG];
  bit done = 0;
  int q_addr[$], q_data[$];
  string q_tag[$];

  always #5 clk = ~clk;

  dep_prefetch_unit #(.NREG(NREG), .DW(DW), .NARC(NARC), .AGE_LIMIT(AGE_LIMIT)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_rdata(int_rdata), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_on_read(cfg_on_read), .cfg_src(cfg_src), .cfg_tgt(cfg_tgt));

  assign int_rdata = core[int_addr];

  always @(posedge clk)
    if (int_req && int_we) begin
      core[int_addr] <= int_wdata;
      if (int_addr == 0) core[1] <= int_wdata + 16'd1;
    end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    cyc++;
    if (bus_rd) begin
      rd_cyc = cyc;
      if (q_addr.size() > 0) begin
        chk(q_tag.pop_front(), int'(bus_rdata), q_data.pop_front());
        void'(q_addr.pop_front());
      end
    end
    if (int_req) begin
      if (int_we) begin wr_cnt[int_addr]++; last_wr[int_addr] = cyc; end
      else        begin rd_cnt[int_addr]++; last_rd[int_addr] = cyc; end
    end
  end

  task automatic bus_read(int a, int exp, string tag);
    @(negedge clk);
    bus_addr = AW'(a);
    bus_rd = 1'b1;
    q_addr.push_back(a);
    q_data.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(int a, int d);
    @(negedge clk);
    bus_addr = AW'(a);
    bus_wdata = DW'(d);
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cfg_arc(int idx, bit v, bit on_rd, int src, int tgt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_valid = v; cfg_on_read = on_rd;
    cfg_src = AW'(src); cfg_tgt = AW'(tgt);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NREG; i++) begin rd_cnt[i] = 0; wr_cnt[i] = 0; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin
      core[i] = DW'(16'h0100 * i + 16'h0011);
      rd_cnt[i] = 0; wr_cnt[i] = 0; last_rd[i] = 0; last_wr[i] = 0;
    end
    bus_addr = 3'd7;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset shadow", int'(bus_rdata), 0);
    chk("R5 reset ready", int'(bus_ready), 1);
    chk("R4 reset int_req", int'(int_req), 0);

    // release reset with a write to 7 already on the bus
    @(negedge clk);
    rst = 1'b0;
    bus_addr = 3'd7; bus_wdata = 16'h0042; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;

    cfg_arc(0, 1, 0, 0, 1);
    cfg_arc(1, 1, 1, 2, 3);
    cfg_arc(2, 0, 1, 4, 6);
    cfg_arc(4, 1, 0, 7, 3);
    cfg_arc(5, 1, 0, 7, 3);
    repeat (30) @(negedge clk);

    chk("R6 write before fetches", int'(last_wr[7] < last_rd[1]), 1);
    chk("R9 urgent before due", int'(last_rd[7] < last_rd[1]), 1);
    chk("R9 due lowest first", int'(last_rd[1] < last_rd[2]), 1);
    for (int i = 0; i < NREG; i++)
      bus_read(i, (i == 7) ? 16'h0042 : 16'h0100 * i + 16'h0011, "R2 R4 initial fill");

    core[5] = 16'h5555;
    core[1] = 16'h7777;
    bus_read(0, 16'h0011, "R1 read 0");
    repeat (10) @(negedge clk);
    bus_read(1, 16'h0111, "R11 read does not fire write arc");

    core[6] = 16'h6666;
    bus_read(4, 16'h0411, "R1 read 4");
    repeat (10) @(negedge clk);
    bus_read(6, 16'h0611, "R11 invalid arc ignored");

    bus_read(3, 16'h0311, "R3 before read arc");
    core[3] = 16'h3333;
    bus_read(2, 16'h0211, "R1 read 2");
    repeat (10) @(negedge clk);
    chk("R8 fire delay", last_rd[3] - rd_cyc, 3);
    bus_read(3, 16'h3333, "R8 read arc refresh");

    bus_write(0, 16'h1234);
    repeat (12) @(negedge clk);
    bus_read(0, 16'h1234, "R7 written reg refetched");
    bus_read(1, 16'h1235, "R7 R6 write arc target");

    clear_counts();
    @(negedge clk);
    bus_addr = 3'd7; bus_wdata = 16'h00A5; bus_wr = 1'b1;
    @(negedge clk);
    #2;
    chk("R5 ready low after write", int'(bus_ready), 0);
    bus_addr = 3'd6; bus_wdata = 16'hBEEF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (20) @(negedge clk);
    chk("R5 ignored write count", wr_cnt[6], 0);
    chk("R5 ignored write core", int'(core[6]), 16'h6666);
    chk("R5 accepted write count", wr_cnt[7], 1);
    chk("R10 single fetch of 3", rd_cnt[3], 1);
    chk("R10 single fetch of 7", rd_cnt[7], 1);
    chk("R9 urgent lowest first", int'(last_rd[3] < last_rd[7]), 1);
    bus_read(7, 16'h00A5, "R7 write 7 refetched");
    bus_read(5, 16'h0511, "R3 stale until age");

    repeat (AGE_LIMIT) @(negedge clk);
    bus_read(5, 16'h5555, "R2 age refresh 5");
    bus_read(6, 16'h6666, "R2 age refresh 6");
    bus_read(1, 16'h1235, "R2 age refresh 1");
    repeat (3) @(negedge clk);
    chk("scoreboard drained", q_addr.size(), 0);
    finish_run();
  end
endmodule